// File: doc/BRIEF.md
# Conditional Data-Processing ALU with Flags

This block executes a single data-processing instruction per cycle for a 32-bit integer pipeline. The caller presents the instruction word together with the first source register value and the already-shifted second operand with its shifter carry. The block first tests the instruction's condition field against its internal N, Z, C and V flag register. When the condition holds, it produces the result of one of sixteen operations and a destination-write strobe, and it updates the flags according to the operation class.

Logical operations take their carry from the shifter and leave overflow alone. Add and subtract forms use a single 33-bit adder, so carry means "no borrow" for subtraction. The four compare/test operations only touch the flags. The result, the write strobe and the flags are all registered and appear one clock after the instruction is issued.

Top module: `dp_alu_core`

## Requirements
- R1: During and right after a synchronous active-low reset, `wr_en_o` is 0, `result_o` is 0 and `flags_o` is 0.
- R2: The condition is `instr_i[31:28]`. Codes 0..15 pass on: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V), always, never. A passing non-compare instruction raises `wr_en_o` on the next cycle.
- R3: When `issue_i` is 0, or the condition fails, `wr_en_o` is 0 on the next cycle and `flags_o` does not change.
- R4: The opcode is `instr_i[24:21]`. The logical results are: 0 rn&op, 1 rn^op, 12 rn|op, 13 op, 14 rn&~op, 15 ~op.
- R5: The arithmetic results are: 2 rn-op, 3 op-rn, 4 rn+op, 5 rn+op+C, 6 rn-op-!C, 7 op-rn-!C.
- R6: A logical opcode (0, 1, 8, 9, 12..15) that updates flags sets N to result bit 31 and Z to (result==0). It takes C from `shc_i` and keeps V.
- R7: An arithmetic opcode (2..7, 10, 11) that updates flags sets N and Z the same way. C is the carry out of the 33-bit sum (1 = no borrow for subtraction) and V is signed overflow.
- R8: Opcodes 8 (rn&op), 9 (rn^op), 10 (rn-op) and 11 (rn+op) update the flags whenever their condition passes, whatever the set-flags bit holds. They never raise `wr_en_o`.
- R9: For the other opcodes, when the set-flags bit `instr_i[20]` is 0 the flags keep their values.
- R10: Outputs change exactly one clock edge after issue. `wr_en_o` lasts one cycle for each issued instruction, and `result_o` holds the last written result.
- `flags_o` is ordered {N,Z,C,V}, with N in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction valid this cycle |
| instr_i | input | 32 | Instruction word (condition, opcode, set-flags bit) |
| rn_i | input | DATA_W | First source operand |
| opd_i | input | DATA_W | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| result_o | output | DATA_W | Registered result of the last writing instruction |
| wr_en_o | output | 1 | Destination-write strobe, one cycle per writing instruction |
| flags_o | output | 4 | Flag register {N,Z,C,V} |

## Verification
The assertions assume that `issue_i` and the instruction fields are valid at each rising edge. They also assume that the upstream shifter's carry is meaningful only when a logical operation consumes it. No other input is assumed to have any particular relationship to the rest. The stimulus is driven on the falling edge, so every field is stable across the sampling edge. About a fifth of the cycles are idle. Operands are mixed between the sign-boundary, zero and all-ones values and free values, so that every condition code meets both flag outcomes as the flags evolve.

// File: rtl/dpalu_pkg.sv
// Package: shared opcode, condition and flag types for the data-processing ALU.
// Assumes the 4-bit opcode and condition encodings listed in the brief.
package dpalu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Compare/test class: flags only, no destination write.
    function automatic logic op_is_compare(input logic [3:0] op);
        return (op[3:2] == 2'b10);
    endfunction

    // Logical class: carry from the shifter, overflow preserved.
    function automatic logic op_is_logical(input logic [3:0] op);
        return (op == OP_AND) || (op == OP_EOR) || (op == OP_TST) ||
               (op == OP_TEQ) || (op[3:2] == 2'b11);
    endfunction

endpackage

// File: rtl/dp_cond_eval.sv
// Condition evaluator: decides from the 4-bit condition code and the
// current flags whether the instruction executes. Purely combinational.
module dp_cond_eval
    import dpalu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  nzcv_t      flags_i,
    output logic       pass_o
);

    // Decode the condition code against the flag values.
    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ:   pass_o = flags_i.z;
            CC_NE:   pass_o = !flags_i.z;
            CC_CS:   pass_o = flags_i.c;
            CC_CC:   pass_o = !flags_i.c;
            CC_MI:   pass_o = flags_i.n;
            CC_PL:   pass_o = !flags_i.n;
            CC_VS:   pass_o = flags_i.v;
            CC_VC:   pass_o = !flags_i.v;
            CC_HI:   pass_o = flags_i.c && !flags_i.z;
            CC_LS:   pass_o = !flags_i.c || flags_i.z;
            CC_GE:   pass_o = (flags_i.n == flags_i.v);
            CC_LT:   pass_o = (flags_i.n != flags_i.v);
            CC_GT:   pass_o = !flags_i.z && (flags_i.n == flags_i.v);
            CC_LE:   pass_o = flags_i.z || (flags_i.n != flags_i.v);
            CC_AL:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dp_logic_unit.sv
// Bitwise unit: produces the logical results (AND, EOR, ORR, MOV, BIC,
// MVN and the TST/TEQ forms). Assumes the caller selects it only for the
// logical class; other opcodes yield don't-care data (zero here).
module dp_logic_unit
    import dpalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] opd_i,
    output logic [DATA_W-1:0] res_o
);

    // Select the bitwise function named by the opcode.
    always_comb begin
        unique case (dp_op_e'(op_i))
            OP_AND, OP_TST: res_o = rn_i & opd_i;
            OP_EOR, OP_TEQ: res_o = rn_i ^ opd_i;
            OP_ORR:         res_o = rn_i | opd_i;
            OP_MOV:         res_o = opd_i;
            OP_BIC:         res_o = rn_i & ~opd_i;
            OP_MVN:         res_o = ~opd_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_arith_unit.sv
// Add/subtract unit: one (DATA_W+1)-bit adder serves all arithmetic
// opcodes. Subtraction adds the inverted subtrahend with carry-in 1 (or
// the incoming C for the borrow forms), so carry-out means "no borrow".
// Assumes it is selected only for opcodes 2..7, 10 and 11.
module dp_arith_unit
    import dpalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] opd_i,
    input  logic              c_in_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_out_o,
    output logic              v_out_o
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] a_op;
    logic [DATA_W-1:0] b_op;
    logic              invert_b;
    logic              carry_in;
    logic [DATA_W-1:0] b_eff;
    logic [SUM_W-1:0]  sum;

    // Steer the operands, the inversion and the carry-in for each opcode.
    always_comb begin
        a_op     = rn_i;
        b_op     = opd_i;
        invert_b = 1'b0;
        carry_in = 1'b0;
        unique case (dp_op_e'(op_i))
            OP_SUB, OP_CMP: begin invert_b = 1'b1; carry_in = 1'b1; end
            OP_RSB: begin a_op = opd_i; b_op = rn_i; invert_b = 1'b1; carry_in = 1'b1; end
            OP_ADD, OP_CMN: carry_in = 1'b0;
            OP_ADC: carry_in = c_in_i;
            OP_SBC: begin invert_b = 1'b1; carry_in = c_in_i; end
            OP_RSC: begin a_op = opd_i; b_op = rn_i; invert_b = 1'b1; carry_in = c_in_i; end
            default: carry_in = 1'b0;
        endcase
    end

    assign b_eff = invert_b ? ~b_op : b_op;

    // Full-width sum with carry-in.
    assign sum     = {1'b0, a_op} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};
    assign res_o   = sum[DATA_W-1:0];
    assign c_out_o = sum[DATA_W];

    // Overflow: both adder inputs share a sign that the result lacks.
    assign v_out_o = (~(a_op[DATA_W-1] ^ b_eff[DATA_W-1])) &
                     (a_op[DATA_W-1] ^ sum[DATA_W-1]);

endmodule

// File: rtl/dp_alu_core.sv
// Conditional data-processing ALU: tests the condition against the flag
// register, computes one of sixteen operations and registers the result,
// a one-cycle write strobe and the updated flags. Assumes operand shifting
// and register-file access are done by the caller. Synchronous
// active-low reset clears all state.
module dp_alu_core
    import dpalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] opd_i,
    input  logic              shc_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);

    localparam int COND_LSB = 28;
    localparam int OPC_LSB  = 21;
    localparam int SET_BIT  = 20;

    logic [3:0]        cond_f;
    logic [3:0]        opc_f;
    logic              set_f;
    logic              instr_unused;
    nzcv_t             flags_q;
    logic              cond_ok;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] arith_res;
    logic              arith_c;
    logic              arith_v;
    logic              is_cmp;
    logic              is_log;
    logic [DATA_W-1:0] alu_res;
    nzcv_t             flags_nxt;
    logic              do_write;
    logic              do_flags;
    logic [DATA_W-1:0] result_q;
    logic              wr_q;

    assign cond_f       = instr_i[COND_LSB +: 4];
    assign opc_f        = instr_i[OPC_LSB +: 4];
    assign set_f        = instr_i[SET_BIT];
    assign instr_unused = ^{instr_i[27:25], instr_i[19:0]};

    dp_cond_eval u_cond (
        .cond_i  (cond_f),
        .flags_i (flags_q),
        .pass_o  (cond_ok)
    );

    dp_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op_i  (opc_f),
        .rn_i  (rn_i),
        .opd_i (opd_i),
        .res_o (logic_res)
    );

    dp_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op_i    (opc_f),
        .rn_i    (rn_i),
        .opd_i   (opd_i),
        .c_in_i  (flags_q.c),
        .res_o   (arith_res),
        .c_out_o (arith_c),
        .v_out_o (arith_v)
    );

    // Classify the opcode and choose the datapath result.
    always_comb begin
        is_cmp  = op_is_compare(opc_f);
        is_log  = op_is_logical(opc_f);
        alu_res = is_log ? logic_res : arith_res;
    end

    // Form next-flag values by operation class.
    always_comb begin
        flags_nxt.n = alu_res[DATA_W-1];
        flags_nxt.z = (alu_res == '0);
        if (is_log) begin
            flags_nxt.c = shc_i;
            flags_nxt.v = flags_q.v;
        end else begin
            flags_nxt.c = arith_c;
            flags_nxt.v = arith_v;
        end
    end

    // Decide which state this instruction may change.
    always_comb begin
        do_write = issue_i && cond_ok && !is_cmp;
        do_flags = issue_i && cond_ok && (set_f || is_cmp);
    end

    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= '0;
        else if (do_flags) flags_q <= flags_nxt;
    end

    // Write strobe and result holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            result_q <= '0;
        end else begin
            wr_q <= do_write;
            if (do_write) result_q <= alu_res;
        end
    end

    assign result_o = result_q;
    assign wr_en_o  = wr_q;
    assign flags_o  = flags_q;

    // Assertions guarding the state-update rules.
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !wr_en_o && $stable(flags_o)); // R3
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !cond_ok |=> !wr_en_o && $stable(flags_o)); // R3
    AST_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && cond_f == 4'hF |=> !wr_en_o); // R2
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && is_cmp |=> !wr_en_o); // R8
    AST_NOSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !set_f && !is_cmp |=> $stable(flags_o)); // R9
    AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && is_log |=> flags_o[0] == $past(flags_o[0])); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !do_write |=> $stable(result_o)); // R10

endmodule

// File: tb/dp_alu_core_bench.sv
// Bench: behavioural reference model compared on every clock.
module dp_alu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_i;
    logic [31:0] instr_i;
    logic [31:0] rn_i;
    logic [31:0] opd_i;
    logic        shc_i;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_res;
    logic        exp_wr;
    logic [3:0]  exp_flags;
    string       tag_wr, tag_fl, tag_res;

    always #10 clk = ~clk;

    dp_alu_core u_dp_alu_core (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .rn_i(rn_i), .opd_i(opd_i), .shc_i(shc_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] corner [5] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1};
        if ($urandom_range(0, 2) == 0) return corner[$urandom_range(0, 4)];
        return $urandom;
    endfunction

    // Reference model: state after the next rising edge.
    task automatic model();
        bit n = exp_flags[3], z = exp_flags[2], c = exp_flags[1], v = exp_flags[0];
        int cc = int'(instr_i[31:28]);
        int op = int'(instr_i[24:21]);
        bit s = instr_i[20];
        bit pass, cmp, logical, upd;
        longint ua = longint'(rn_i), ub = longint'(opd_i);
        longint sa = longint'($signed(rn_i)), sb = longint'($signed(opd_i));
        longint us, ss, x, y, sx, sy;
        longint cin = longint'(c);
        logic [31:0] r;
        bit nc, nv;
        case (cc)
            0: pass = z;            1: pass = !z;
            2: pass = c;            3: pass = !c;
            4: pass = n;            5: pass = !n;
            6: pass = v;            7: pass = !v;
            8: pass = c && !z;      9: pass = !c || z;
            10: pass = (n == v);    11: pass = (n != v);
            12: pass = !z && (n == v); 13: pass = z || (n != v);
            14: pass = 1;           default: pass = 0;
        endcase
        cmp = (op >= 8 && op <= 11);
        logical = (op == 0 || op == 1 || op == 8 || op == 9 || op >= 12);
        nc = c; nv = v; r = '0;
        if (logical) begin
            case (op)
                0, 8: r = rn_i & opd_i;
                1, 9: r = rn_i ^ opd_i;
                12: r = rn_i | opd_i;
                13: r = opd_i;
                14: r = rn_i & ~opd_i;
                default: r = ~opd_i;
            endcase
            nc = shc_i;
        end else begin
            // swap for reverse forms
            if (op == 3 || op == 7) begin x = ub; y = ua; sx = sb; sy = sa; end
            else begin x = ua; y = ub; sx = sa; sy = sb; end
            if (op == 4 || op == 5 || op == 11) begin
                us = x + y + ((op == 5) ? cin : 0);
                ss = sx + sy + ((op == 5) ? cin : 0);
                nc = (us > 64'hFFFF_FFFF);
            end else begin
                us = x - y - ((op == 6 || op == 7) ? (1 - cin) : 0);
                ss = sx - sy - ((op == 6 || op == 7) ? (1 - cin) : 0);
                nc = (us >= 0);
            end
            r  = us[31:0];
            nv = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end
        upd = issue_i && pass && (s || cmp);
        tag_wr = !issue_i ? "R3" : (cmp ? "R8" : "R2");
        tag_fl = (!issue_i || !pass) ? "R3" : (cmp ? "R8" : (!s ? "R9" : (logical ? "R6" : "R7")));
        tag_res = logical ? "R4" : "R5";
        if (exp_wr && !(issue_i && pass && !cmp)) tag_wr = "R10";
        exp_wr = issue_i && pass && !cmp;
        if (exp_wr) exp_res = r;
        if (upd) exp_flags = {r[31], r == 0, nc, nv};
    endtask

    task automatic compare_outputs();
        check(tag_wr, "wr_en", {31'b0, wr_en_o}, {31'b0, exp_wr});
        check(tag_fl, "flags", {28'b0, flags_o}, {28'b0, exp_flags});
        if (exp_wr) check(tag_res, "result", result_o, exp_res);
        else        check("R10", "result hold", result_o, exp_res);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; rn_i = '0; opd_i = '0; shc_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "wr_en", {31'b0, wr_en_o}, 32'd0);
        check("R1", "result", result_o, 32'd0);
        check("R1", "flags", {28'b0, flags_o}, 32'd0);
        rst_n = 1'b1;
        exp_res = '0; exp_wr = 1'b0; exp_flags = '0;
        tag_wr = "R1"; tag_fl = "R1"; tag_res = "R1";

        // R10: directed latency check with MOV always, value 5
        @(negedge clk);
        issue_i = 1'b1; instr_i = {4'hE, 3'b000, 4'd13, 1'b0, 20'h0}; rn_i = 32'h0; opd_i = 32'd5;
        #1 check("R10", "wr_en before edge", {31'b0, wr_en_o}, 32'd0);
        model();
        @(negedge clk);
        check("R10", "wr_en after edge", {31'b0, wr_en_o}, 32'd1);
        check("R10", "result after edge", result_o, 32'd5);
        issue_i = 1'b0;
        model();
        @(negedge clk);
        check("R10", "wr_en one cycle", {31'b0, wr_en_o}, 32'd0);
        check("R10", "result held", result_o, 32'd5);

        // Directed R7: CMP 0 - 1 borrows and sets N; then ADDS overflow.
        issue_i = 1'b1; instr_i = {4'hE, 3'b000, 4'd10, 1'b0, 20'h0}; rn_i = 32'h0; opd_i = 32'h1;
        model();
        @(negedge clk);
        check("R8", "flags after CMP", {28'b0, flags_o}, 32'h8);
        instr_i = {4'hE, 3'b000, 4'd4, 1'b1, 20'h0}; rn_i = 32'h7FFF_FFFF; opd_i = 32'h1;
        model();
        @(negedge clk);
        check("R7", "flags after ADDS overflow", {28'b0, flags_o}, 32'h9);
        check("R5", "ADDS result", result_o, 32'h8000_0000);
        compare_outputs();

        // Random traffic, compared on every clock.
        for (int i = 0; i < 4000; i++) begin
            issue_i = ($urandom_range(0, 4) != 0);
            instr_i = {$urandom_range(0, 15) > 13 ? 4'hE : 4'($urandom_range(0, 15)),
                       3'b000, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 20'($urandom)};
            rn_i = pick(); opd_i = pick(); shc_i = 1'($urandom_range(0, 1));
            model();
            @(negedge clk);
            compare_outputs();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule